// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers the event pulses of a network interface into a 32-bit cause register. It also holds an enable mask and drives a single interrupt line toward the host. Three event inputs are provided: receive queue 0, transmit queue 0 and a link status change. The two queue events do not have fixed cause bits. Each one passes through a small allocation register that holds a destination index and a valid flag, so software decides which cause bit each queue raises.

The host reaches the block through a simple word-addressed register port with separate read and write strobes. Read data appears one cycle after the read strobe. The register map is:

| Address | Name | Behaviour |
|---|---|---|
| 0 | cause | A read returns the cause register. A write of ones clears those bits. |
| 1 | cause-set | A write ORs the data into the cause register. |
| 2 | mask | A write ORs the data into the mask. A read returns the mask. |
| 3 | mask-clear | A write clears the mask bits written as one. |
| 4 | auto-clear | Read/write. Selects which bits a cause read clears. |
| 5 | auto-mask | Read/write. Selects which bits have their mask bit dropped when raised. |
| 6 | queue map | Read/write allocation register. |
| 7 | holdoff | Read/write interval that suppresses the line after the host services it. |

Top module: `intc_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A write to address 1 ORs the written bits into the cause register. A write to address 0 clears the cause bits written as one.
- R3: A write to address 2 ORs bits into the mask. A write to address 3 clears the written bits. A read of address 2 returns the mask.
- R4: A pulse on `evLink` sets cause bit 20.
- R5: The queue map at address 6 works as follows. Bits 6:0 give the cause index for `evRxQ0`, and bit 7 is that entry's valid flag. Bits 14:8 give the index for `evTxQ0`, and bit 15 is its valid flag. A queue event sets the indexed cause bit only when the entry is valid and the index is below 32. Otherwise the event is dropped.
- R6: A read of address 0 returns the cause register and, at the same edge, clears the cause bits selected by the auto-clear register. If an event or cause-set write targets the same bit in the same cycle, the set wins.
- R7: When any source sets a cause bit whose auto-mask bit is one, the matching mask bit is cleared in the same cycle.
- R8: While no holdoff runs, `irq` is high exactly when the AND of cause and mask is nonzero.
- R9: The holdoff register keeps a unit count in bits 11:3. Each read of address 0 forces `irq` low for count × 4 clock cycles. A count of zero gives no holdoff.
- R10: Reads of write-only addresses (1, 3) and of addresses 8 and above return zero. Writes to addresses 8 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after `regRdEn` |
| evRxQ0 | input | 1 | Receive queue 0 event pulse |
| evTxQ0 | input | 1 | Transmit queue 0 event pulse |
| evLink | input | 1 | Link status change pulse |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situation to reach is a collision of two sources on one cause bit. This happens when the host reads the cause register with that bit selected for auto-clear, and an event sets the same bit in the same cycle. The bench drives the read strobe and the link pulse on the same falling edge, then reads the cause register again to confirm the bit survived. The holdoff window is equally narrow. The bench counts edges after the servicing read and samples `irq` on the last cycle of the window and on the first cycle after it.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int REG_CAUSE    = 0;
  localparam int REG_CAUSESET = 1;
  localparam int REG_MASK     = 2;
  localparam int REG_MASKCLR  = 3;
  localparam int REG_AUTOCLR  = 4;
  localparam int REG_AUTOMASK = 5;
  localparam int REG_QMAP     = 6;
  localparam int REG_HOLDOFF  = 7;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic causeRd;
    logic causeClr;
    logic causeSet;
    logic maskSet;
    logic maskClr;
    logic autoClrWr;
    logic autoMaskWr;
    logic qmapWr;
    logic holdWr;
  } intc_strobe_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  output intc_strobe_t       stb,
  output logic [2:0]         rdSel,
  output logic               rdHit
);

  always_comb begin
    stb   = '0;
    rdHit = 1'b0;
    rdSel = regAddr[2:0];
    if (regWrEn) begin
      case (regAddr)
        ADDR_W'(REG_CAUSE):    stb.causeClr   = 1'b1;
        ADDR_W'(REG_CAUSESET): stb.causeSet   = 1'b1;
        ADDR_W'(REG_MASK):     stb.maskSet    = 1'b1;
        ADDR_W'(REG_MASKCLR):  stb.maskClr    = 1'b1;
        ADDR_W'(REG_AUTOCLR):  stb.autoClrWr  = 1'b1;
        ADDR_W'(REG_AUTOMASK): stb.autoMaskWr = 1'b1;
        ADDR_W'(REG_QMAP):     stb.qmapWr     = 1'b1;
        ADDR_W'(REG_HOLDOFF):  stb.holdWr     = 1'b1;
        default: ;
      endcase
    end
    if (regRdEn) begin
      case (regAddr)
        ADDR_W'(REG_CAUSE): begin
          stb.causeRd = 1'b1;
          rdHit       = 1'b1;
        end
        ADDR_W'(REG_MASK),
        ADDR_W'(REG_AUTOCLR),
        ADDR_W'(REG_AUTOMASK),
        ADDR_W'(REG_QMAP),
        ADDR_W'(REG_HOLDOFF):  rdHit = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int CAUSE_W     = 32,
  parameter int LINK_BIT    = 20,
  parameter int UNITS_W     = 9,
  parameter int TICK_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  intc_strobe_t       stb,
  input  logic [2:0]         rdSel,
  input  logic               rdHit,
  input  logic [CAUSE_W-1:0] wrData,
  input  logic               evRx,
  input  logic               evTx,
  input  logic               evLink,
  output logic [CAUSE_W-1:0] rdData,
  output logic               irq,
  output logic [CAUSE_W-1:0] causeVec,
  output logic [CAUSE_W-1:0] maskVec,
  output logic [CAUSE_W-1:0] acVec,
  output logic [CAUSE_W-1:0] amVec,
  output logic [UNITS_W-1:0] holdUnits
);

  localparam int NQ     = 2;
  localparam int IDX_W  = $clog2(CAUSE_W);
  localparam int HOLD_W = UNITS_W + $clog2(TICK_CYCLES + 1);

  logic [CAUSE_W-1:0] causeQ, maskQ, acQ, amQ;
  logic [NQ*8-1:0]    qmapQ;
  logic [UNITS_W-1:0] unitsQ;
  logic [HOLD_W-1:0]  holdQ, holdD;
  logic [NQ-1:0]      qEv;
  logic [CAUSE_W-1:0] qSet [NQ];
  logic [CAUSE_W-1:0] setBits, clrBits, causeD, maskD;

  assign qEv = {evTx, evRx};

  // Queue-to-cause routing, one lane per queue entry of the map.
  for (genvar q = 0; q < NQ; q++) begin : g_route
    logic [6:0] idx;
    logic       valid;
    logic       hit;
    assign idx   = qmapQ[q*8 +: 7];
    assign valid = qmapQ[q*8 + 7];
    assign hit   = qEv[q] && valid && (int'(idx) < CAUSE_W);
    assign qSet[q] = hit ? (CAUSE_W'(1) << idx[IDX_W-1:0]) : '0;
  end

  always_comb begin
    setBits = stb.causeSet ? wrData : '0;
    for (int q = 0; q < NQ; q++) setBits = setBits | qSet[q];
    if (evLink) setBits[LINK_BIT] = 1'b1;
    clrBits = (stb.causeClr ? wrData : '0) | (stb.causeRd ? acQ : '0);
    causeD  = (causeQ & ~clrBits) | setBits;
    maskD   = (maskQ | (stb.maskSet ? wrData : '0))
            & ~(stb.maskClr ? wrData : '0)
            & ~(setBits & amQ);
  end

  always_comb begin
    if (stb.causeRd)
      holdD = HOLD_W'(unitsQ) * HOLD_W'(TICK_CYCLES);
    else if (holdQ != '0)
      holdD = holdQ - HOLD_W'(1);
    else
      holdD = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      maskQ  <= '0;
      acQ    <= '0;
      amQ    <= '0;
      qmapQ  <= '0;
      unitsQ <= '0;
      holdQ  <= '0;
      rdData <= '0;
    end else begin
      causeQ <= causeD;
      maskQ  <= maskD;
      holdQ  <= holdD;
      if (stb.autoClrWr)  acQ    <= wrData;
      if (stb.autoMaskWr) amQ    <= wrData;
      if (stb.qmapWr)     qmapQ  <= wrData[NQ*8-1:0];
      if (stb.holdWr)     unitsQ <= wrData[UNITS_W+2:3];
      if (!rdHit) rdData <= '0;
      else begin
        case (rdSel)
          3'(REG_CAUSE):    rdData <= causeQ;
          3'(REG_MASK):     rdData <= maskQ;
          3'(REG_AUTOCLR):  rdData <= acQ;
          3'(REG_AUTOMASK): rdData <= amQ;
          3'(REG_QMAP):     rdData <= CAUSE_W'(qmapQ);
          3'(REG_HOLDOFF):  rdData <= CAUSE_W'({unitsQ, 3'b000});
          default:          rdData <= '0;
        endcase
      end
    end
  end

  assign irq       = (|(causeQ & maskQ)) && (holdQ == '0);
  assign causeVec  = causeQ;
  assign maskVec   = maskQ;
  assign acVec     = acQ;
  assign amVec     = amQ;
  assign holdUnits = unitsQ;

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int CAUSE_W     = 32,
  parameter int ADDR_W      = 4,
  parameter int LINK_BIT    = 20,
  parameter int UNITS_W     = 9,
  parameter int TICK_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CAUSE_W-1:0] regWrData,
  output logic [CAUSE_W-1:0] regRdData,
  input  logic               evRxQ0,
  input  logic               evTxQ0,
  input  logic               evLink,
  output logic               irq
);

  intc_strobe_t       stb;
  logic [2:0]         rdSel;
  logic               rdHit;
  logic [CAUSE_W-1:0] causeVec, maskVec, acVec, amVec;
  logic [UNITS_W-1:0] holdUnits;

  intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .stb     (stb),
    .rdSel   (rdSel),
    .rdHit   (rdHit)
  );

  intc_dp #(
    .CAUSE_W    (CAUSE_W),
    .LINK_BIT   (LINK_BIT),
    .UNITS_W    (UNITS_W),
    .TICK_CYCLES(TICK_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdSel     (rdSel),
    .rdHit     (rdHit),
    .wrData    (regWrData),
    .evRx      (evRxQ0),
    .evTx      (evTxQ0),
    .evLink    (evLink),
    .rdData    (regRdData),
    .irq       (irq),
    .causeVec  (causeVec),
    .maskVec   (maskVec),
    .acVec     (acVec),
    .amVec     (amVec),
    .holdUnits (holdUnits)
  );

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int CAUSE_W  = 32,
  parameter int ADDR_W   = 4,
  parameter int LINK_BIT = 20,
  parameter int UNITS_W  = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [CAUSE_W-1:0] regWrData,
  input logic               evRxQ0,
  input logic               evTxQ0,
  input logic               evLink,
  input logic               irq,
  input logic [CAUSE_W-1:0] causeVec,
  input logic [CAUSE_W-1:0] maskVec,
  input logic [CAUSE_W-1:0] acVec,
  input logic [CAUSE_W-1:0] amVec,
  input logic [UNITS_W-1:0] holdUnits
);

  // R2
  cause_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(1)) |=>
      ((causeVec & $past(regWrData)) == $past(regWrData)));

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(3)) |=>
      ((maskVec & $past(regWrData)) == '0));

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(2) && amVec == '0) |=>
      ((maskVec & $past(regWrData)) == $past(regWrData)));

  // R4
  link_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    evLink |=> causeVec[LINK_BIT]);

  // R6
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(0) && !evRxQ0 && !evTxQ0 && !evLink &&
     !(regWrEn && regAddr == ADDR_W'(1))) |=>
      ((causeVec & $past(acVec)) == '0));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((causeVec & maskVec) == '0) |-> !irq);

  // R9
  holdoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(0) && holdUnits != '0) |=> !irq);

endmodule

bind intc_top intc_checker #(
  .CAUSE_W (CAUSE_W),
  .ADDR_W  (ADDR_W),
  .LINK_BIT(LINK_BIT),
  .UNITS_W (UNITS_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evRxQ0    (evRxQ0),
  .evTxQ0    (evTxQ0),
  .evLink    (evLink),
  .irq       (irq),
  .causeVec  (causeVec),
  .maskVec   (maskVec),
  .acVec     (acVec),
  .amVec     (amVec),
  .holdUnits (holdUnits)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evRxQ0 = 1'b0, evTxQ0 = 1'b0, evLink = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intc_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .evRxQ0(evRxQ0), .evTxQ0(evTxQ0), .evLink(evLink), .irq(irq)
  );

  // kind: 0 write, 1 read and compare, 2 event pulse (bit0 rx, bit1 tx, bit2 link)
  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd6, 32'h0000_8180, 32'h0, 4'd5},  // R5 rx->0, tx->1
    '{2'd2, 4'd0, 32'h1,         32'h0, 4'd5},
    '{2'd1, 4'd0, 32'h0,         32'h0000_0001, 4'd5},
    '{2'd2, 4'd0, 32'h6,         32'h0, 4'd4},  // R4 tx + link
    '{2'd1, 4'd0, 32'h0,         32'h0010_0003, 4'd4},
    '{2'd0, 4'd0, 32'h3,         32'h0, 4'd2},  // R2 write-one clear
    '{2'd1, 4'd0, 32'h0,         32'h0010_0000, 4'd2},
    '{2'd0, 4'd6, 32'h0000_0A85, 32'h0, 4'd5},  // rx->5 valid, tx->10 invalid
    '{2'd2, 4'd0, 32'h3,         32'h0, 4'd5},
    '{2'd1, 4'd0, 32'h0,         32'h0010_0020, 4'd5},
    '{2'd0, 4'd6, 32'h0000_C0C0, 32'h0, 4'd5},  // index 64, out of range
    '{2'd2, 4'd0, 32'h3,         32'h0, 4'd5},
    '{2'd1, 4'd0, 32'h0,         32'h0010_0020, 4'd5},
    '{2'd0, 4'd1, 32'h8000_0000, 32'h0, 4'd2},  // R2 cause-set
    '{2'd1, 4'd0, 32'h0,         32'h8010_0020, 4'd2},
    '{2'd0, 4'd2, 32'h0000_F00F, 32'h0, 4'd3},  // R3
    '{2'd0, 4'd3, 32'h0000_0F03, 32'h0, 4'd3},
    '{2'd1, 4'd2, 32'h0,         32'h0000_F00C, 4'd3},
    '{2'd1, 4'd3, 32'h0,         32'h0, 4'd10}, // R10 write-only reads zero
    '{2'd1, 4'd1, 32'h0,         32'h0, 4'd10},
    '{2'd1, 4'd9, 32'h0,         32'h0, 4'd10},
    '{2'd0, 4'd9, 32'hFFFF_FFFF, 32'h0, 4'd10},
    '{2'd1, 4'd2, 32'h0,         32'h0000_F00C, 4'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic doEvent(input logic [2:0] bits);
    @(negedge clk);
    {evLink, evTxQ0, evRxQ0} = bits;
    @(negedge clk);
    {evLink, evTxQ0, evRxQ0} = 3'b000;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      doRead(4'(a), rd);
      check($sformatf("R1 reg%0d", a), rd, 32'h0);
    end

    // Table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        2'd0: doWrite(VECS[i].addr, VECS[i].data);
        2'd1: begin
          doRead(VECS[i].addr, rd);
          check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
        end
        default: doEvent(VECS[i].data[2:0]);
      endcase
    end

    // R8: no overlap, then overlap on bit 5
    check("R8 irq low", {31'b0, irq}, 32'h0);
    doWrite(4'd2, 32'h20);
    check("R8 irq high", {31'b0, irq}, 32'h1);

    // R6 auto-clear on read
    doWrite(4'd4, 32'h20);
    doRead(4'd0, rd);
    check("R6 first read", rd, 32'h8010_0020);
    doRead(4'd0, rd);
    check("R6 after clear", rd, 32'h8010_0000);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R6 set wins over auto-clear in the same cycle
    doWrite(4'd4, 32'h0010_0000);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 4'd0; evLink = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0; evLink = 1'b0;
    doRead(4'd0, rd);
    check("R6 set wins", rd, 32'h8010_0000);
    doWrite(4'd0, 32'hFFFF_FFFF);
    doWrite(4'd4, 32'h0);
    doRead(4'd0, rd);
    check("R2 clear all", rd, 32'h0);

    // R7 auto-mask
    doWrite(4'd3, 32'hFFFF_FFFF);
    doWrite(4'd2, 32'h6);
    doWrite(4'd5, 32'h4);
    doWrite(4'd1, 32'h6);
    doRead(4'd2, rd);
    check("R7 mask", rd, 32'h2);
    check("R8 irq via bit1", {31'b0, irq}, 32'h1);

    // R9 holdoff: 2 units x 4 cycles
    doWrite(4'd7, 32'h10);
    doRead(4'd7, rd);
    check("R9 readback", rd, 32'h10);
    doRead(4'd0, rd);
    check("R9 cause", rd, 32'h6);
    check("R9 held low start", {31'b0, irq}, 32'h0);
    repeat (7) @(posedge clk);
    @(negedge clk);
    check("R9 held low last", {31'b0, irq}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R9 released", {31'b0, irq}, 32'h1);
    doWrite(4'd7, 32'h0);
    doRead(4'd0, rd);
    check("R9 zero interval", {31'b0, irq}, 32'h1);

    done = 1'b1;
    finishRun();
  end

endmodule